// File: doc/BRIEF.md
# Vertical Scan Timing Generator

This block is the vertical half of a display controller's raster timing. A host programs it through an indexed register pair: one I/O address takes a register number, and the next address up reads or writes the register that number selects. Two such address pairs exist, and an input picks which one is decoded. The frame height and the last visible line are each assembled from several registers. In the legacy layout, each value's two top bits sit in a shared overflow register. In the extended layout, each value instead takes a 4-bit nibble from its own extension register.

Each pulse of `line_tick` marks one horizontal line. The block counts lines from 0, wraps at the end of the frame, and holds `vde` high on the visible lines. The programmed numbers are offset-encoded. The total field holds the frame height minus 2. The display-end field holds the number of the last visible line, which is the visible line count minus 1. New settings are copied into working copies only when the counter wraps, so a frame in progress always completes with the values it started with.

Top module: `vscan_timing`

## Requirements
- R1: With `mono_sel`=1 the index port is address 0x3B4 and the data port is 0x3B5; with `mono_sel`=0 they are 0x3D4 and 0x3D5. A write to the index port sets the index, and reading it returns the index. Writes to any other address are ignored, and reads from any other address return 0.
- R2: Indexes 0x06 (total low byte), 0x07 (overflow) and 0x12 (display-end low byte) are 8-bit read/write through the data port. Every index not named in R2 or R3 reads 0 and ignores writes.
- R3: Indexes 0x30 (total extension) and 0x31 (display-end extension) store data bits 3:0 only. Bits 7:4 always read back as 0.
- R4: With `ext_mode`=0 the total is {0x07 bit 5, 0x07 bit 0, 0x06[7:0]} and the display end is {0x07 bit 6, 0x07 bit 1, 0x12[7:0]}. The extension registers have no effect.
- R5: With `ext_mode`=1 the total is {0x30[3:0], 0x06[7:0]} and the display end is {0x31[3:0], 0x12[7:0]}. The overflow register has no effect.
- R6: A frame holds exactly total+2 lines. `line_cnt` runs from 0 to total+1 and then returns to 0.
- R7: `vde` is 1 while `line_cnt` ≤ display end and 0 otherwise, so each frame has min(display end+1, total+2) visible lines.
- R8: `line_cnt` changes only on a clock edge where `line_tick`=1.
- R9: Register and `ext_mode` changes take effect only at the next wrap to line 0. The frame in progress keeps its length.
- R10: After reset all registers and the index are 0 and `line_cnt` is 0. The first frame is therefore 2 lines long, with `vde` high on line 0 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mono_sel | input | 1 | Address pair select: 1 = 0x3B4/0x3B5, 0 = 0x3D4/0x3D5 |
| ext_mode | input | 1 | 1 = 12-bit extended layout, 0 = 10-bit legacy layout |
| io_we | input | 1 | Write strobe for the host port |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, combinational from `io_addr` |
| line_tick | input | 1 | One pulse per horizontal line |
| line_cnt | output | 13 | Current scanline number |
| vde | output | 1 | Vertical display enable |

## Verification
Reads are combinational, so the bench sets the address on a falling edge and samples `io_rdata` a moment later in the same half cycle. A register write lands on the next rising edge. `line_cnt` and `vde` move one rising edge after a tick. New settings appear only in the first full frame after the next wrap. For that reason the bench, after programming, first waits for the counter to leave 0 and then for it to return to 0, and only then counts lines and visible lines on falling edges until the next return to 0. The mid-frame case records the last line number seen before the wrap and compares it with the old total+1.

// File: rtl/vst_pkg.sv
package vst_pkg;
    localparam logic [7:0] IX_VT_LO  = 8'h06;
    localparam logic [7:0] IX_OVF    = 8'h07;
    localparam logic [7:0] IX_DE_LO  = 8'h12;
    localparam logic [7:0] IX_VT_EXT = 8'h30;
    localparam logic [7:0] IX_DE_EXT = 8'h31;

    typedef struct packed {
        logic [7:0] idx;
        logic [7:0] vt_lo;
        logic [7:0] ovf;
        logic [7:0] de_lo;
        logic [3:0] vt_ext;
        logic [3:0] de_ext;
    } vst_regs_t;
endpackage

// File: rtl/vst_regfile.sv
module vst_regfile
    import vst_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] MONO_BASE  = 16'h03B4,
    parameter logic [15:0] COLOR_BASE = 16'h03D4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mono_sel,
    input  logic              io_we,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output vst_regs_t         regs
);
    vst_regs_t regs_d, regs_q;
    logic [ADDR_W-1:0] base;
    logic hit_idx, hit_dat;

    always_comb begin
        base    = mono_sel ? ADDR_W'(MONO_BASE) : ADDR_W'(COLOR_BASE);
        hit_idx = (io_addr == base);
        hit_dat = (io_addr == base + ADDR_W'(1));
    end

    always_comb begin
        regs_d = regs_q;
        if (io_we && hit_idx) begin
            regs_d.idx = io_wdata;
        end else if (io_we && hit_dat) begin
            case (regs_q.idx)
                IX_VT_LO:  regs_d.vt_lo  = io_wdata;
                IX_OVF:    regs_d.ovf    = io_wdata;
                IX_DE_LO:  regs_d.de_lo  = io_wdata;
                IX_VT_EXT: regs_d.vt_ext = io_wdata[3:0];
                IX_DE_EXT: regs_d.de_ext = io_wdata[3:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        io_rdata = 8'h00;
        if (hit_idx) begin
            io_rdata = regs_q.idx;
        end else if (hit_dat) begin
            case (regs_q.idx)
                IX_VT_LO:  io_rdata = regs_q.vt_lo;
                IX_OVF:    io_rdata = regs_q.ovf;
                IX_DE_LO:  io_rdata = regs_q.de_lo;
                IX_VT_EXT: io_rdata = {4'h0, regs_q.vt_ext};
                IX_DE_EXT: io_rdata = {4'h0, regs_q.de_ext};
                default:   io_rdata = 8'h00;
            endcase
        end
    end

    assign regs = regs_q;
endmodule

// File: rtl/vst_assemble.sv
module vst_assemble
    import vst_pkg::*;
#(
    parameter int VAL_W = 12
) (
    input  vst_regs_t        regs,
    input  logic             ext_mode,
    output logic [VAL_W-1:0] tot,
    output logic [VAL_W-1:0] dend
);
    always_comb begin
        if (ext_mode) begin
            tot  = VAL_W'({regs.vt_ext, regs.vt_lo});
            dend = VAL_W'({regs.de_ext, regs.de_lo});
        end else begin
            tot  = VAL_W'({regs.ovf[5], regs.ovf[0], regs.vt_lo});
            dend = VAL_W'({regs.ovf[6], regs.ovf[1], regs.de_lo});
        end
    end
endmodule

// File: rtl/vst_counter.sv
module vst_counter #(
    parameter int VAL_W = 12,
    parameter int CNT_W = VAL_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_tick,
    input  logic [VAL_W-1:0] tot_in,
    input  logic [VAL_W-1:0] dend_in,
    output logic [CNT_W-1:0] line_cnt,
    output logic             vde,
    output logic [VAL_W-1:0] act_tot,
    output logic [VAL_W-1:0] act_dend
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [VAL_W-1:0] tot;
        logic [VAL_W-1:0] dend;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic last_line;

    always_comb begin
        st_d      = st_q;
        last_line = (st_q.cnt == CNT_W'(st_q.tot) + CNT_W'(1));
        if (line_tick) begin
            if (last_line) begin
                st_d.cnt  = '0;
                st_d.tot  = tot_in;
                st_d.dend = dend_in;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_cnt = st_q.cnt;
    assign vde      = (st_q.cnt <= CNT_W'(st_q.dend));
    assign act_tot  = st_q.tot;
    assign act_dend = st_q.dend;
endmodule

// File: rtl/vscan_timing.sv
module vscan_timing
    import vst_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] MONO_BASE  = 16'h03B4,
    parameter logic [15:0] COLOR_BASE = 16'h03D4,
    parameter int          VAL_W      = 12,
    localparam int         CNT_W      = VAL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mono_sel,
    input  logic              ext_mode,
    input  logic              io_we,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              line_tick,
    output logic [CNT_W-1:0]  line_cnt,
    output logic              vde
);
    vst_regs_t        regs;
    logic [VAL_W-1:0] tot_new, dend_new;
    logic [VAL_W-1:0] act_tot, act_dend;

    vst_regfile #(
        .ADDR_W(ADDR_W), .MONO_BASE(MONO_BASE), .COLOR_BASE(COLOR_BASE)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .mono_sel(mono_sel), .io_we(io_we),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata), .regs(regs)
    );

    vst_assemble #(.VAL_W(VAL_W)) i_asm (
        .regs(regs), .ext_mode(ext_mode), .tot(tot_new), .dend(dend_new)
    );

    vst_counter #(.VAL_W(VAL_W), .CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
        .tot_in(tot_new), .dend_in(dend_new),
        .line_cnt(line_cnt), .vde(vde),
        .act_tot(act_tot), .act_dend(act_dend)
    );
endmodule

// File: rtl/vst_checker.sv
module vst_checker #(
    parameter int VAL_W = 12,
    parameter int CNT_W = VAL_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_tick,
    input logic [CNT_W-1:0] line_cnt,
    input logic             vde,
    input logic [VAL_W-1:0] act_tot,
    input logic [VAL_W-1:0] act_dend
);
    // R8: counter frozen without a tick
    a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(line_cnt));

    // R6: a tick before the last line steps by one
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && line_cnt != CNT_W'(act_tot) + CNT_W'(1))
        |=> line_cnt == $past(line_cnt) + CNT_W'(1));

    // R6: a tick on the last line returns to 0
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && line_cnt == CNT_W'(act_tot) + CNT_W'(1)) |=> line_cnt == '0);

    // R6: counter never passes total+1
    a_r6_bound: assert property (@(posedge clk) disable iff (!rst_n)
        line_cnt <= CNT_W'(act_tot) + CNT_W'(1));

    // R9: working copies change only as the counter lands on 0
    a_r9_frame_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(act_tot) || !$stable(act_dend)) |-> line_cnt == '0);

    // R7: display enable rises only at frame start
    a_r7_vde_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vde) |-> line_cnt == '0);
endmodule

bind vscan_timing vst_checker i_vst_checker (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .line_cnt(line_cnt),
    .vde(vde), .act_tot(act_tot), .act_dend(act_dend)
);

// File: tb/test_vscan_timing.sv
`timescale 1ns/1ps
module test_vscan_timing;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mono_sel = 1'b0;
    logic        ext_mode = 1'b0;
    logic        io_we = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic        line_tick = 1'b0;
    logic [12:0] line_cnt;
    logic        vde;

    int total = 0;
    int bad = 0;
    bit done = 0;

    vscan_timing i_vscan_timing (
        .clk(clk), .rst_n(rst_n), .mono_sel(mono_sel), .ext_mode(ext_mode),
        .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .line_tick(line_tick), .line_cnt(line_cnt), .vde(vde)
    );

    always #4 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] base_addr();
        return mono_sel ? 16'h03B4 : 16'h03D4;
    endfunction

    task automatic bus_wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_we = 1'b1;
        @(negedge clk);
        io_we = 1'b0;
    endtask

    task automatic reg_wr(logic [7:0] ix, logic [7:0] d);
        bus_wr(base_addr(), ix);
        bus_wr(base_addr() + 16'd1, d);
    endtask

    task automatic reg_rd(logic [7:0] ix, output int v);
        bus_wr(base_addr(), ix);
        io_addr = base_addr() + 16'd1;
        #1 v = io_rdata;
    endtask

    task automatic measure(output int len, output int act);
        @(negedge clk);
        while (line_cnt == 0) @(negedge clk);
        while (line_cnt != 0) @(negedge clk);
        len = 0; act = 0;
        do begin
            len++;
            if (vde) act++;
            @(negedge clk);
        end while (line_cnt != 0);
    endtask

    function automatic int exp_act(int tot, int de);
        return (de + 1 < tot + 2) ? de + 1 : tot + 2;
    endfunction

    task automatic prog_check(string rq, int mode, int vl, int ov, int dl, int vx, int dx);
        int len, act, tot, de;
        ext_mode = mode[0];
        reg_wr(8'h06, vl[7:0]); reg_wr(8'h07, ov[7:0]); reg_wr(8'h12, dl[7:0]);
        reg_wr(8'h30, vx[7:0]); reg_wr(8'h31, dx[7:0]);
        if (mode != 0) begin
            tot = (vx & 15) * 256 + vl;
            de  = (dx & 15) * 256 + dl;
        end else begin
            tot = ((ov >> 5) & 1) * 512 + (ov & 1) * 256 + vl;
            de  = ((ov >> 6) & 1) * 512 + ((ov >> 1) & 1) * 256 + dl;
        end
        measure(len, act);
        chk({rq, " R6 frame length"}, len, tot + 2);
        chk({rq, " R7 visible lines"}, act, exp_act(tot, de));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v, len, act, prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 reset state
        chk("R10 line_cnt at reset", line_cnt, 0);
        chk("R10 vde at reset", vde, 1);
        reg_rd(8'h06, v); chk("R10 reg06 reset", v, 0);
        reg_rd(8'h07, v); chk("R10 reg07 reset", v, 0);
        line_tick = 1'b1;
        measure(len, act);
        chk("R10 first frame length", len, 2);
        chk("R10 first frame visible", act, 1);

        // R2 readback
        reg_wr(8'h06, 8'hA5); reg_rd(8'h06, v); chk("R2 reg06 readback", v, 8'hA5);
        reg_wr(8'h07, 8'h5A); reg_rd(8'h07, v); chk("R2 reg07 readback", v, 8'h5A);
        reg_wr(8'h12, 8'h3C); reg_rd(8'h12, v); chk("R2 reg12 readback", v, 8'h3C);
        reg_wr(8'h55, 8'hFF); reg_rd(8'h55, v); chk("R2 unused index reads 0", v, 0);
        // R3 reserved upper nibble
        reg_wr(8'h30, 8'hFF); reg_rd(8'h30, v); chk("R3 reg30 upper nibble 0", v, 8'h0F);
        reg_wr(8'h31, 8'hE9); reg_rd(8'h31, v); chk("R3 reg31 upper nibble 0", v, 8'h09);

        // R1 index port readback and pair selection
        bus_wr(base_addr(), 8'h12);
        io_addr = base_addr(); #1 chk("R1 index readback", io_rdata, 8'h12);
        mono_sel = 1'b1;
        bus_wr(16'h03D4, 8'h06);
        bus_wr(16'h03D5, 8'h11);
        io_addr = 16'h03D5; #1 chk("R1 other pair reads 0", io_rdata, 0);
        io_addr = 16'h03B5; #1 chk("R1 index unchanged by other pair", io_rdata, 8'h3C);
        reg_rd(8'h06, v); chk("R1 other pair write ignored", v, 8'hA5);
        reg_wr(8'h06, 8'h77); reg_rd(8'h06, v); chk("R1 mono pair write", v, 8'h77);
        io_addr = 16'h0000; #1 chk("R1 unrelated address reads 0", io_rdata, 0);
        mono_sel = 1'b0;

        // R4 legacy sweep over overflow bits, extension bits set to show no effect
        for (int t = 0; t < 4; t++)
            for (int d = 0; d < 4; d++) begin
                int ov = ((t >> 1) << 5) | (t & 1) | ((d >> 1) << 6) | ((d & 1) << 1);
                prog_check("R4", 0, 5, ov, 3 + 4 * t, 15, 15);
            end
        // R5 extended sweep, overflow register set to show no effect
        for (int t = 0; t < 4; t++)
            for (int d = 0; d < 4; d++)
                prog_check("R5", 1, 9, 8'hFF, 200, t, d);
        // R7 display end beyond frame
        prog_check("R7", 0, 7, 0, 40, 0, 0);

        // R9 mid-frame change keeps current frame
        prog_check("R9 setup", 0, 40, 0, 20, 0, 0);
        @(negedge clk);
        while (line_cnt != 0) @(negedge clk);
        reg_wr(8'h06, 8'd10);
        ext_mode = 1'b1;
        prev = line_cnt;
        while (line_cnt != 0) begin prev = line_cnt; @(negedge clk); end
        chk("R9 old frame completes", prev, 41);
        ext_mode = 1'b0;
        measure(len, act);
        chk("R9 new length next frame", len, 12);

        // R8 hold without tick
        line_tick = 1'b0;
        @(negedge clk);
        prev = line_cnt;
        repeat (5) @(negedge clk);
        chk("R8 counter held", line_cnt, prev);
        line_tick = 1'b1;
        @(negedge clk);
        chk("R8 counter advances on tick", line_cnt, (prev + 1) % 12);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule